// File: doc/BRIEF.md
# Embedded Controller Host Port

This block is the controller side of a two-port host interface to an embedded controller. It serves a byte-wide host I/O bus. The host reaches an internal 256-byte register space only through a short handshake: a command byte, then an address byte, then (for writes) a data byte. Two flags pace the exchange. IBF, in status bit 1, means a host byte is still waiting to be consumed. OBF, in status bit 0, means a byte is waiting for the host. The host polls these flags before each transfer.

There are two ports, picked by `host_port_sel`. The data port is selected by 0, and each read returns the output byte. The combined port is selected by 1; a read returns status and a write delivers a command. On the back end the block issues single-cycle read and write strobes into the register space. Read data is sampled combinationally in the same cycle as the read strobe. The block also handles burst-mode bookkeeping and a query command. The query always reports that no event is pending.

Top module: `ec_host_port`

## Requirements
- R1: After reset the status byte is 0x00 and neither register strobe is active.
- R2: Any host write sets IBF on the next cycle. Status bit 3 is then 1 if the write went to the command port and 0 if it went to the data port.
- R3: IBF stays set for exactly IBF_LAT cycles after a host write, then clears as the byte is consumed.
- R4: After command 0x80 followed by an address byte, exactly one read strobe carries that address. OBF sets in the same cycle that IBF clears, and the data port returns the register value.
- R5: After command 0x81, an address byte and a data byte, exactly one write strobe carries that address and data. It is issued when the data byte is consumed.
- R6: A host read of the data port clears OBF. Reads of the status port leave OBF unchanged.
- R7: Command 0x82 loads 0x90 into the output byte, sets OBF and sets status bit 4. Command 0x83 clears bit 4 and does not set OBF.
- R8: Command 0x84 loads 0x00 into the output byte and sets OBF.
- R9: A data-port byte that arrives with no command pending causes no strobe and no OBF. IBF still clears after IBF_LAT cycles.
- R10: A command byte other than 0x80 to 0x84 is dropped. The byte after it is then treated as a data byte with no command pending.
- R11: A command byte that arrives in the middle of a sequence abandons that sequence and starts the new one.
- R12: Status bits 2, 5, 6 and 7 always read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe |
| host_port_sel | input | 1 | 0 selects the data port, 1 selects the status/command port |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Output byte (sel 0) or status byte (sel 1) |
| reg_rd_o | output | 1 | Register-space read strobe |
| reg_wr_o | output | 1 | Register-space write strobe |
| reg_addr_o | output | 8 | Register address for either strobe |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data, valid in the read-strobe cycle |

## Verification
The hardest situation to reach from the ports is a sequence cut short by a new command. The sequencer must drop a half-finished write after the address byte has been consumed. No write strobe may escape, and the new read must use the new address. The bench drives 0x81 and an address, then issues 0x80 with a different address. It counts strobes and compares the returned byte against an arithmetic pattern. A sweep of all 251 undefined command bytes, each followed by a data byte, shows that every one of them returns the sequencer to idle.

// File: rtl/ec_pkg.sv
package ec_pkg;

  localparam logic [7:0] OPC_RD        = 8'h80;
  localparam logic [7:0] OPC_WR        = 8'h81;
  localparam logic [7:0] OPC_BURST_ON  = 8'h82;
  localparam logic [7:0] OPC_BURST_OFF = 8'h83;
  localparam logic [7:0] OPC_QUERY     = 8'h84;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_RD_ADDR,
    SQ_WR_ADDR,
    SQ_WR_DATA
  } seq_state_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_READ,
    OP_WRITE,
    OP_BURST_ON,
    OP_BURST_OFF,
    OP_QUERY
  } op_e;

  function automatic op_e decode_cmd(input logic [7:0] b);
    case (b)
      OPC_RD:        return OP_READ;
      OPC_WR:        return OP_WRITE;
      OPC_BURST_ON:  return OP_BURST_ON;
      OPC_BURST_OFF: return OP_BURST_OFF;
      OPC_QUERY:     return OP_QUERY;
      default:       return OP_NONE;
    endcase
  endfunction

  // status layout: [4] burst, [3] last byte was command, [1] IBF, [0] OBF
  function automatic logic [7:0] pack_status(input logic obf, input logic ibf,
                                             input logic was_cmd, input logic burst);
    return {3'b000, burst, was_cmd, 1'b0, ibf, obf};
  endfunction

endpackage

// File: rtl/ec_in_latch.sv
module ec_in_latch #(
  parameter int IBF_LAT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       port_sel,
  input  logic [7:0] wdata,
  output logic       ibf,
  output logic       in_is_cmd,
  output logic [7:0] in_byte,
  output logic       consume
);
  localparam int CW = (IBF_LAT > 1) ? $clog2(IBF_LAT) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(IBF_LAT - 1);

  logic [CW-1:0] cnt_q;

  assign consume = ibf && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibf       <= 1'b0;
      in_is_cmd <= 1'b0;
      in_byte   <= 8'h00;
      cnt_q     <= '0;
    end else if (host_wr) begin
      ibf       <= 1'b1;
      in_is_cmd <= port_sel;
      in_byte   <= wdata;
      cnt_q     <= CNT_LOAD;
    end else if (ibf) begin
      if (cnt_q == '0) ibf <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // R2
  ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> (ibf && (in_is_cmd == $past(port_sel))));

  // R3
  ibf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !host_wr) |=> !ibf);

endmodule

// File: rtl/ec_out_latch.sv
module ec_out_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       host_take,
  output logic       obf,
  output logic [7:0] out_byte
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obf      <= 1'b0;
      out_byte <= 8'h00;
    end else if (load) begin
      obf      <= 1'b1;
      out_byte <= load_byte;
    end else if (host_take) begin
      obf      <= 1'b0;
    end
  end

  // R6
  obf_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_take && !load) |=> !obf);

  // R6
  obf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (obf && !host_take) |=> obf);

endmodule

// File: rtl/ec_sequencer.sv
module ec_sequencer
  import ec_pkg::*;
#(
  parameter logic [7:0] BURST_ACK  = 8'h90,
  parameter logic [7:0] QUERY_NONE = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       consume,
  input  logic       in_is_cmd,
  input  logic [7:0] in_byte,
  input  logic [7:0] reg_rdata_i,
  output logic       reg_rd,
  output logic       reg_wr,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       obf_load,
  output logic [7:0] obf_byte,
  output logic       burst
);
  seq_state_e st_q;
  logic [7:0] addr_q;
  op_e        op;
  logic       cmd_ev;
  logic       data_ev;

  assign op      = decode_cmd(in_byte);
  assign cmd_ev  = consume && in_is_cmd;
  assign data_ev = consume && !in_is_cmd;

  assign reg_rd    = data_ev && (st_q == SQ_RD_ADDR);
  assign reg_wr    = data_ev && (st_q == SQ_WR_DATA);
  assign reg_addr  = (st_q == SQ_RD_ADDR) ? in_byte : addr_q;
  assign reg_wdata = in_byte;

  assign obf_load = reg_rd || (cmd_ev && ((op == OP_BURST_ON) || (op == OP_QUERY)));
  assign obf_byte = reg_rd ? reg_rdata_i :
                    (op == OP_BURST_ON) ? BURST_ACK : QUERY_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      addr_q <= 8'h00;
      burst  <= 1'b0;
    end else if (cmd_ev) begin
      case (op)
        OP_READ:      st_q <= SQ_RD_ADDR;
        OP_WRITE:     st_q <= SQ_WR_ADDR;
        OP_BURST_ON:  begin burst <= 1'b1; st_q <= SQ_IDLE; end
        OP_BURST_OFF: begin burst <= 1'b0; st_q <= SQ_IDLE; end
        default:      st_q <= SQ_IDLE;
      endcase
    end else if (data_ev) begin
      case (st_q)
        SQ_WR_ADDR: begin addr_q <= in_byte; st_q <= SQ_WR_DATA; end
        default:    st_q <= SQ_IDLE;
      endcase
    end
  end

  // R7
  burst_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ev && (in_byte == OPC_BURST_ON)) |=> burst);

  // R7
  burst_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ev && (in_byte == OPC_BURST_OFF)) |=> !burst);

  // R11
  cmd_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ev && (in_byte == OPC_RD)) |=> (st_q == SQ_RD_ADDR));

endmodule

// File: rtl/ec_host_port.sv
module ec_host_port
  import ec_pkg::*;
#(
  parameter int         IBF_LAT    = 2,
  parameter logic [7:0] BURST_ACK  = 8'h90,
  parameter logic [7:0] QUERY_NONE = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic       host_port_sel,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       reg_rd_o,
  output logic       reg_wr_o,
  output logic [7:0] reg_addr_o,
  output logic [7:0] reg_wdata_o,
  input  logic [7:0] reg_rdata_i
);
  logic       ibf, in_is_cmd, consume;
  logic [7:0] in_byte;
  logic       obf_load, obf, burst;
  logic [7:0] obf_byte, out_byte;
  logic       host_take;
  logic [7:0] status;

  assign host_take = host_rd && !host_port_sel;

  ec_in_latch #(.IBF_LAT(IBF_LAT)) u_in (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (host_wr),
    .port_sel  (host_port_sel),
    .wdata     (host_wdata),
    .ibf       (ibf),
    .in_is_cmd (in_is_cmd),
    .in_byte   (in_byte),
    .consume   (consume)
  );

  ec_sequencer #(.BURST_ACK(BURST_ACK), .QUERY_NONE(QUERY_NONE)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .consume     (consume),
    .in_is_cmd   (in_is_cmd),
    .in_byte     (in_byte),
    .reg_rdata_i (reg_rdata_i),
    .reg_rd      (reg_rd_o),
    .reg_wr      (reg_wr_o),
    .reg_addr    (reg_addr_o),
    .reg_wdata   (reg_wdata_o),
    .obf_load    (obf_load),
    .obf_byte    (obf_byte),
    .burst       (burst)
  );

  ec_out_latch u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (obf_load),
    .load_byte (obf_byte),
    .host_take (host_take),
    .obf       (obf),
    .out_byte  (out_byte)
  );

  assign status     = pack_status(obf, ibf, in_is_cmd, burst);
  assign host_rdata = host_port_sel ? status : out_byte;

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd_o && reg_wr_o));

  // R9
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_o || reg_wr_o) |-> (consume && !in_is_cmd));

  // R4
  read_obf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_o |=> (obf && !ibf));

  // R5
  write_no_obf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_o && !obf && !host_wr) |=> !obf);

endmodule

// File: tb/ec_host_port_tb_top.sv
module ec_host_port_tb_top;
  localparam int IBF_LAT = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic       host_port_sel = 1'b1;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       reg_rd_o, reg_wr_o;
  logic [7:0] reg_addr_o, reg_wdata_o, reg_rdata_i;

  logic [7:0] mem [256];
  int wr_cnt = 0, rd_cnt = 0;
  logic [7:0] last_wa = 8'h00, last_wd = 8'h00, last_ra = 8'h00;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  ec_host_port #(.IBF_LAT(IBF_LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_port_sel(host_port_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .reg_rd_o(reg_rd_o), .reg_wr_o(reg_wr_o), .reg_addr_o(reg_addr_o),
    .reg_wdata_o(reg_wdata_o), .reg_rdata_i(reg_rdata_i)
  );

  assign reg_rdata_i = mem[reg_addr_o];

  always @(posedge clk) begin
    if (rst_n) begin
      if (reg_wr_o) begin
        mem[reg_addr_o] <= reg_wdata_o;
        wr_cnt++; last_wa = reg_addr_o; last_wd = reg_wdata_o;
      end
      if (reg_rd_o) begin
        rd_cnt++; last_ra = reg_addr_o;
      end
    end
  end

  function automatic logic [7:0] pattern(input int a);
    return 8'((a * 37 + 91) % 256);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // write a byte, then poll status and check IBF timing and reserved bits
  task automatic send(input bit sel, input logic [7:0] b);
    @(negedge clk);
    host_port_sel = sel; host_wdata = b; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_port_sel = 1'b1; host_rd = 1'b1;
    #1;
    chk(host_rdata[1] == 1'b1, "R2 ibf set", host_rdata[1], 1);
    chk(host_rdata[3] == sel, "R2 cmd flag", host_rdata[3], sel);
    chk((host_rdata & 8'hE4) == 8'h00, "R12 reserved bits", host_rdata, 0);
    begin
      int n = 0;
      while (host_rdata[1] && n < 100) begin
        n++;
        @(negedge clk); #1;
      end
      chk(n == IBF_LAT, "R3 ibf latency", n, IBF_LAT);
    end
    host_rd = 1'b0;
  endtask

  task automatic read_data(output logic [7:0] v);
    @(negedge clk);
    host_port_sel = 1'b0; host_rd = 1'b1; #1;
    v = host_rdata;
    @(negedge clk);
    host_rd = 1'b0; host_port_sel = 1'b1; #1;
    chk(host_rdata[0] == 1'b0, "R6 obf cleared by data read", host_rdata[0], 0);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    int w0;
    w0 = wr_cnt;
    send(1'b1, 8'h81); send(1'b0, a); send(1'b0, d);
    #1;
    chk(wr_cnt == w0 + 1, "R5 one write strobe", wr_cnt - w0, 1);
    chk(last_wa == a && last_wd == d, "R5 write addr/data", {last_wa, last_wd}, {a, d});
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] v);
    int r0;
    r0 = rd_cnt;
    send(1'b1, 8'h80); send(1'b0, a);
    #1;
    chk(rd_cnt == r0 + 1, "R4 one read strobe", rd_cnt - r0, 1);
    chk(last_ra == a, "R4 read address", last_ra, a);
    chk(host_rdata[0] == 1'b1, "R4 obf set, R6 kept by status reads", host_rdata[0], 1);
    read_data(v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int w0, r0;
    repeat (3) @(negedge clk);
    #1;
    // R1
    chk(host_rdata == 8'h00, "R1 reset status", host_rdata, 0);
    chk(!reg_rd_o && !reg_wr_o, "R1 strobes idle", {reg_rd_o, reg_wr_o}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(host_rdata == 8'h00, "R1 status after release", host_rdata, 0);

    // R9: data byte with nothing pending
    w0 = wr_cnt; r0 = rd_cnt;
    send(1'b0, 8'h5A); #1;
    chk(wr_cnt == w0 && rd_cnt == r0, "R9 no strobe", wr_cnt + rd_cnt, w0 + r0);
    chk(host_rdata[0] == 1'b0, "R9 no obf", host_rdata[0], 0);

    // R5 sweep: write every address
    for (int a = 0; a < 256; a++) do_write(8'(a), pattern(a));
    // R4 sweep: read every address
    for (int a = 0; a < 256; a++) begin
      do_read(8'(a), v);
      chk(v == pattern(a), "R4 read data", v, pattern(a));
    end

    // R7 burst on / off
    send(1'b1, 8'h82); #1;
    chk(host_rdata[0] == 1'b1, "R7 burst ack obf", host_rdata[0], 1);
    chk(host_rdata[4] == 1'b1, "R7 burst bit set", host_rdata[4], 1);
    read_data(v);
    chk(v == 8'h90, "R7 burst ack byte", v, 8'h90);
    do_read(8'h07, v);
    chk(v == pattern(7), "R7 read while burst", v, pattern(7));
    send(1'b1, 8'h83); #1;
    chk(host_rdata[4] == 1'b0, "R7 burst bit cleared", host_rdata[4], 0);
    chk(host_rdata[0] == 1'b0, "R7 no obf on disable", host_rdata[0], 0);

    // R8 query
    send(1'b1, 8'h84); #1;
    chk(host_rdata[0] == 1'b1, "R8 query obf", host_rdata[0], 1);
    read_data(v);
    chk(v == 8'h00, "R8 query byte", v, 0);

    // R11 write abandoned by a read command
    w0 = wr_cnt;
    send(1'b1, 8'h81); send(1'b0, 8'h10);
    do_read(8'h20, v);
    chk(v == pattern(32), "R11 new read data", v, pattern(32));
    send(1'b0, 8'hEE); #1;
    chk(wr_cnt == w0, "R11 abandoned write dropped", wr_cnt - w0, 0);

    // R10 sweep of undefined commands
    for (int c = 0; c < 256; c++) begin
      if (c < 8'h80 || c > 8'h84) begin
        w0 = wr_cnt; r0 = rd_cnt;
        send(1'b1, 8'(c)); send(1'b0, 8'h33); #1;
        chk(wr_cnt == w0 && rd_cnt == r0, "R10 unknown cmd no strobe",
            wr_cnt + rd_cnt, w0 + r0);
        chk(host_rdata[0] == 1'b0, "R10 unknown cmd no obf", host_rdata[0], 0);
      end
    end

    finish_run();
  end
endmodule